// File: doc/BRIEF.md
# Frame-synchronous shadow and busy-lock register file

This block is the configuration and result front end of a frame-based image statistics engine. Software reaches it over a simple word-addressed request/response bus. The block holds two classes of setting. Deferred settings can be written at any moment, but the engine only picks them up at the next frame start. Locked settings are frozen for the whole time the engine is busy.

The block also runs the enable/busy handshake, in one of two modes. In one-shot mode the frames come from memory, and each enable covers exactly one frame. In continuous mode the frames come from a video stream: frames run back to back while enable stays set, and a disable issued mid-frame lets the current frame finish. A small internal array of saturating bin counters stands in for the statistics memory. It counts hits only while a frame is in progress, keeps its counts across frames until software clears it, and answers reads with a fixed poison word while the engine is busy.

Address map (word addresses, default parameters):

| Address | Contents |
|---------|----------|
| 0 | CTRL: bit 0 = enable, bit 1 = mode (0 one-shot, 1 continuous) |
| 1 | STATUS: bit 0 = busy |
| 2, 3 | Deferred (shadowed) settings |
| 4, 5 | Locked settings |
| 6 | Bin clear: writing 1 to bit 0 clears all bins |
| 32 to 39 | Bin counters 0 to 7, zero-extended |

Top module: `fsr_regfile`

## Requirements
- R1: After reset, busy is 0, both active-setting outputs are 0, and every register and bin reads as 0.
- R2: A write to a deferred register (address 2 or 3) reads back at once. The act_shadow output keeps its old value until a frame_start pulse. On that edge it takes the last written value. The commit happens on every frame_start, whether or not a frame begins.
- R3: A frame_start sampled while idle with CTRL bit 0 set makes busy 1 one cycle later. A frame_end sampled while busy makes busy 0 one cycle later.
- R4: While busy, writes to the locked registers (addresses 4 and 5), to CTRL bit 1 and to the bin clear register are accepted on the bus but change nothing.
- R5: Once busy is 0, the locked registers take writes again, and lock_cfg shows the new value one cycle after the write.
- R6: A read of a bin address returns 32'hDEADBEEF while busy and the bin count while idle. bus_be has no effect on the value returned by any read.
- R7: In one-shot mode (CTRL bit 1 = 0), hardware clears CTRL bit 0 when a frame starts, so a later frame_start does not start another frame until software sets enable again.
- R8: In continuous mode (CTRL bit 1 = 1), enable stays set across frames, so back-to-back frames run. Clearing enable during a frame keeps busy at 1 until that frame's frame_end, and no further frame starts after it.
- R9: A hit_valid cycle increments bin hit_bin only while busy. Counts add up across frames, saturate at 2^CNT_W-1, and return to 0 when bit 0 of the clear register is written with 1 while idle.
- R10: Every request gets exactly one response on the next cycle, with bus_resp = 2'b00 (OKAY), including blocked writes. No response appears without a request.
- R11: On a write to a deferred or locked register, only the bytes whose bus_be bit is set are updated.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_req | input | 1 | Request strobe, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Word address |
| bus_wdata | input | DW | Write data |
| bus_be | input | DW/8 | Byte enables for writes |
| bus_rvalid | output | 1 | Response valid, one cycle after the request |
| bus_rdata | output | DW | Read data (0 for writes) |
| bus_resp | output | 2 | Response code, always 2'b00 |
| frame_start | input | 1 | Start-of-frame pulse |
| frame_end | input | 1 | End-of-frame pulse |
| hit_valid | input | 1 | Statistics hit strobe |
| hit_bin | input | $clog2(NUM_BINS) | Bin index of the hit |
| busy | output | 1 | Frame in progress |
| act_shadow | output | NUM_SHADOW*DW | Active copies of the deferred settings, register 0 in the low word |
| lock_cfg | output | NUM_LOCK*DW | Locked settings, register 0 in the low word |

## Verification
A wrong busy flag shows up within one cycle: busy itself, the poison word on bin reads, and lock writes that land or are dropped all depend on it. A deferred copy that commits at the wrong time changes act_shadow on a cycle without frame_start, and this can be seen at once. A stuck or mis-cleared enable only shows at the next frame_start, as a frame that starts when it should not, or fails to start when it should. Miscounted or uncleared bins show on the first idle read after the frame.

// File: rtl/fsr_pkg.sv
package fsr_pkg;
    typedef logic [1:0] resp_t;
    localparam resp_t RESP_OKAY = 2'b00;

    typedef enum logic {
        MODE_ONESHOT    = 1'b0,
        MODE_CONTINUOUS = 1'b1
    } run_mode_e;

    typedef struct packed {
        logic      enable;
        run_mode_e mode;
        logic      busy;
    } frame_state_t;
endpackage

// File: rtl/fsr_frame_ctrl.sv
module fsr_frame_ctrl
    import fsr_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic frame_start,
    input  logic frame_end,
    input  logic ctrl_wr,
    input  logic wr_enable,
    input  logic wr_mode,
    output logic enable,
    output logic mode,
    output logic busy
);
    frame_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (ctrl_wr) begin
            st_d.enable = wr_enable;
            if (!st_q.busy) begin
                st_d.mode = run_mode_e'(wr_mode);
            end
        end
        if (st_q.busy) begin
            if (frame_end) begin
                st_d.busy = 1'b0;
            end
        end else if (frame_start && st_q.enable) begin
            st_d.busy = 1'b1;
            if (st_q.mode == MODE_ONESHOT) begin
                st_d.enable = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{enable: 1'b0, mode: MODE_ONESHOT, busy: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign enable = st_q.enable;
    assign mode   = st_q.mode;
    assign busy   = st_q.busy;
endmodule

// File: rtl/fsr_reg_bank.sv
module fsr_reg_bank #(
    parameter int N        = 2,
    parameter int DW       = 32,
    parameter bit SHADOWED = 1'b1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [N-1:0]    wr_en,
    input  logic [DW-1:0]   wdata,
    input  logic [DW/8-1:0] be,
    input  logic            commit,
    output logic [N*DW-1:0] sw_val,
    output logic [N*DW-1:0] act_val
);
    localparam int NB = DW / 8;

    logic [DW-1:0] pend_d [N];
    logic [DW-1:0] pend_q [N];

    always_comb begin
        for (int i = 0; i < N; i++) begin
            pend_d[i] = pend_q[i];
            if (wr_en[i]) begin
                for (int b = 0; b < NB; b++) begin
                    if (be[b]) begin
                        pend_d[i][b*8 +: 8] = wdata[b*8 +: 8];
                    end
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < N; i++) begin
                pend_q[i] <= '0;
            end
        end else begin
            for (int i = 0; i < N; i++) begin
                pend_q[i] <= pend_d[i];
            end
        end
    end

    for (genvar g = 0; g < N; g++) begin : g_flat
        assign sw_val[g*DW +: DW] = pend_q[g];
    end

    if (SHADOWED) begin : g_shadow
        logic [DW-1:0] act_d [N];
        logic [DW-1:0] act_q [N];

        always_comb begin
            for (int i = 0; i < N; i++) begin
                act_d[i] = commit ? pend_q[i] : act_q[i];
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                for (int i = 0; i < N; i++) begin
                    act_q[i] <= '0;
                end
            end else begin
                for (int i = 0; i < N; i++) begin
                    act_q[i] <= act_d[i];
                end
            end
        end

        for (genvar g = 0; g < N; g++) begin : g_act
            assign act_val[g*DW +: DW] = act_q[g];
        end
    end else begin : g_direct
        assign act_val = sw_val;
    end
endmodule

// File: rtl/fsr_bin_store.sv
module fsr_bin_store #(
    parameter int NUM_BINS = 8,
    parameter int CNT_W    = 16,
    localparam int IDX_W   = $clog2(NUM_BINS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hit_valid,
    input  logic [IDX_W-1:0] hit_bin,
    input  logic             count_en,
    input  logic             clear,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [CNT_W-1:0] rd_count
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic [CNT_W-1:0] cnt_d [NUM_BINS];
    logic [CNT_W-1:0] cnt_q [NUM_BINS];

    always_comb begin
        for (int i = 0; i < NUM_BINS; i++) begin
            cnt_d[i] = cnt_q[i];
            if (clear) begin
                cnt_d[i] = '0;
            end else if (hit_valid && count_en && (int'(hit_bin) == i)
                         && (cnt_q[i] != CNT_MAX)) begin
                cnt_d[i] = cnt_q[i] + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_BINS; i++) begin
                cnt_q[i] <= '0;
            end
        end else begin
            for (int i = 0; i < NUM_BINS; i++) begin
                cnt_q[i] <= cnt_d[i];
            end
        end
    end

    always_comb begin
        rd_count = '0;
        for (int i = 0; i < NUM_BINS; i++) begin
            if (int'(rd_idx) == i) begin
                rd_count = cnt_q[i];
            end
        end
    end
endmodule

// File: rtl/fsr_regfile.sv
module fsr_regfile
    import fsr_pkg::*;
#(
    parameter int          ADDR_W     = 6,
    parameter int          DW         = 32,
    parameter int          NUM_SHADOW = 2,
    parameter int          NUM_LOCK   = 2,
    parameter int          NUM_BINS   = 8,
    parameter int          CNT_W      = 16,
    parameter logic [31:0] POISON     = 32'hDEADBEEF,
    localparam int         IDX_W      = $clog2(NUM_BINS),
    localparam int         BE_W       = DW / 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     bus_req,
    input  logic                     bus_we,
    input  logic [ADDR_W-1:0]        bus_addr,
    input  logic [DW-1:0]            bus_wdata,
    input  logic [BE_W-1:0]          bus_be,
    output logic                     bus_rvalid,
    output logic [DW-1:0]            bus_rdata,
    output logic [1:0]               bus_resp,
    input  logic                     frame_start,
    input  logic                     frame_end,
    input  logic                     hit_valid,
    input  logic [IDX_W-1:0]         hit_bin,
    output logic                     busy,
    output logic [NUM_SHADOW*DW-1:0] act_shadow,
    output logic [NUM_LOCK*DW-1:0]   lock_cfg
);
    localparam int CTRL_A   = 0;
    localparam int STAT_A   = 1;
    localparam int SH_BASE  = 2;
    localparam int LK_BASE  = SH_BASE + NUM_SHADOW;
    localparam int CLR_A    = LK_BASE + NUM_LOCK;
    localparam int BIN_BASE = 2 ** (ADDR_W - 1);
    localparam int BIN_END  = BIN_BASE + NUM_BINS;

    typedef struct packed {
        logic          rvalid;
        logic [DW-1:0] rdata;
    } rsp_state_t;

    rsp_state_t rsp_d, rsp_q;

    logic                      wr_go;
    logic                      rd_go;
    logic                      ctrl_wr;
    logic                      bin_clear;
    logic                      in_bin_win;
    logic [NUM_SHADOW-1:0]     sh_wr;
    logic [NUM_LOCK-1:0]       lk_wr;
    logic [NUM_SHADOW*DW-1:0]  sh_sw;
    logic [NUM_LOCK*DW-1:0]    lk_sw;
    logic [NUM_LOCK*DW-1:0]    lk_act;
    logic                      en_q;
    logic                      mode_q;
    logic                      busy_q;
    logic [CNT_W-1:0]          bin_count;
    logic [IDX_W-1:0]          bin_idx;
    logic [DW-1:0]             rd_mux;

    assign wr_go      = bus_req && bus_we;
    assign rd_go      = bus_req && !bus_we;
    assign ctrl_wr    = wr_go && (int'(bus_addr) == CTRL_A) && bus_be[0];
    assign bin_clear  = wr_go && (int'(bus_addr) == CLR_A) && bus_be[0]
                        && bus_wdata[0] && !busy_q;
    assign in_bin_win = (int'(bus_addr) >= BIN_BASE) && (int'(bus_addr) < BIN_END);
    assign bin_idx    = bus_addr[IDX_W-1:0];

    always_comb begin
        for (int i = 0; i < NUM_SHADOW; i++) begin
            sh_wr[i] = wr_go && (int'(bus_addr) == SH_BASE + i);
        end
        for (int i = 0; i < NUM_LOCK; i++) begin
            lk_wr[i] = wr_go && !busy_q && (int'(bus_addr) == LK_BASE + i);
        end
    end

    fsr_frame_ctrl i_frame_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .frame_start (frame_start),
        .frame_end   (frame_end),
        .ctrl_wr     (ctrl_wr),
        .wr_enable   (bus_wdata[0]),
        .wr_mode     (bus_wdata[1]),
        .enable      (en_q),
        .mode        (mode_q),
        .busy        (busy_q)
    );

    fsr_reg_bank #(
        .N        (NUM_SHADOW),
        .DW       (DW),
        .SHADOWED (1'b1)
    ) i_shadow_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (sh_wr),
        .wdata   (bus_wdata),
        .be      (bus_be),
        .commit  (frame_start),
        .sw_val  (sh_sw),
        .act_val (act_shadow)
    );

    fsr_reg_bank #(
        .N        (NUM_LOCK),
        .DW       (DW),
        .SHADOWED (1'b0)
    ) i_lock_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (lk_wr),
        .wdata   (bus_wdata),
        .be      (bus_be),
        .commit  (1'b0),
        .sw_val  (lk_sw),
        .act_val (lk_act)
    );

    fsr_bin_store #(
        .NUM_BINS (NUM_BINS),
        .CNT_W    (CNT_W)
    ) i_bin_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .hit_valid (hit_valid),
        .hit_bin   (hit_bin),
        .count_en  (busy_q),
        .clear     (bin_clear),
        .rd_idx    (bin_idx),
        .rd_count  (bin_count)
    );

    always_comb begin
        rd_mux = '0;
        if (int'(bus_addr) == CTRL_A) begin
            rd_mux[1:0] = {mode_q, en_q};
        end else if (int'(bus_addr) == STAT_A) begin
            rd_mux[0] = busy_q;
        end else if (in_bin_win) begin
            rd_mux = busy_q ? POISON[DW-1:0] : DW'(bin_count);
        end else begin
            for (int i = 0; i < NUM_SHADOW; i++) begin
                if (int'(bus_addr) == SH_BASE + i) begin
                    rd_mux = sh_sw[i*DW +: DW];
                end
            end
            for (int i = 0; i < NUM_LOCK; i++) begin
                if (int'(bus_addr) == LK_BASE + i) begin
                    rd_mux = lk_sw[i*DW +: DW];
                end
            end
        end
    end

    always_comb begin
        rsp_d.rvalid = bus_req;
        rsp_d.rdata  = rd_go ? rd_mux : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rsp_q <= '0;
        end else begin
            rsp_q <= rsp_d;
        end
    end

    assign bus_rvalid = rsp_q.rvalid;
    assign bus_rdata  = rsp_q.rdata;
    assign bus_resp   = RESP_OKAY;
    assign busy       = busy_q;
    assign lock_cfg   = lk_act;
endmodule

// File: rtl/fsr_checker.sv
module fsr_checker
    import fsr_pkg::*;
#(
    parameter int          ADDR_W     = 6,
    parameter int          DW         = 32,
    parameter int          NUM_SHADOW = 2,
    parameter int          NUM_LOCK   = 2,
    parameter int          NUM_BINS   = 8,
    parameter logic [31:0] POISON     = 32'hDEADBEEF
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     bus_req,
    input logic                     bus_we,
    input logic [ADDR_W-1:0]        bus_addr,
    input logic                     bus_rvalid,
    input logic [DW-1:0]            bus_rdata,
    input logic [1:0]               bus_resp,
    input logic                     frame_start,
    input logic                     frame_end,
    input logic                     busy,
    input logic [NUM_SHADOW*DW-1:0] act_shadow,
    input logic [NUM_LOCK*DW-1:0]   lock_cfg
);
    localparam int BIN_BASE = 2 ** (ADDR_W - 1);
    localparam int BIN_END  = BIN_BASE + NUM_BINS;

    logic bin_read_busy;
    assign bin_read_busy = bus_req && !bus_we && busy
                           && (int'(bus_addr) >= BIN_BASE) && (int'(bus_addr) < BIN_END);

    AST_BUSY_RISE_ON_SOF: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(frame_start)); // R3
    AST_BUSY_FALL_ON_EOF: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> $past(frame_end)); // R3
    AST_ACT_HOLD_NO_SOF: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_start |=> $stable(act_shadow)); // R2
    AST_LOCK_HOLD_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(lock_cfg)); // R4
    AST_POISON_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        bin_read_busy |=> (bus_rdata == POISON[DW-1:0])); // R6
    AST_ONE_RESP: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req |=> (bus_rvalid && (bus_resp == RESP_OKAY))); // R10
    AST_NO_SPURIOUS_RESP: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_req |=> !bus_rvalid); // R10
endmodule

bind fsr_regfile fsr_checker #(
    .ADDR_W     (ADDR_W),
    .DW         (DW),
    .NUM_SHADOW (NUM_SHADOW),
    .NUM_LOCK   (NUM_LOCK),
    .NUM_BINS   (NUM_BINS),
    .POISON     (POISON)
) i_fsr_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_req     (bus_req),
    .bus_we      (bus_we),
    .bus_addr    (bus_addr),
    .bus_rvalid  (bus_rvalid),
    .bus_rdata   (bus_rdata),
    .bus_resp    (bus_resp),
    .frame_start (frame_start),
    .frame_end   (frame_end),
    .busy        (busy),
    .act_shadow  (act_shadow),
    .lock_cfg    (lock_cfg)
);

// File: tb/test_fsr_regfile.sv
module test_fsr_regfile;
    localparam int ADDR_W = 6;
    localparam int DW     = 32;
    localparam int CNT_W  = 4;
    localparam logic [31:0] POISON = 32'hDEADBEEF;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              bus_req = 1'b0;
    logic              bus_we = 1'b0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic [DW-1:0]     bus_wdata = '0;
    logic [3:0]        bus_be = '0;
    logic              bus_rvalid;
    logic [DW-1:0]     bus_rdata;
    logic [1:0]        bus_resp;
    logic              frame_start = 1'b0;
    logic              frame_end = 1'b0;
    logic              hit_valid = 1'b0;
    logic [2:0]        hit_bin = '0;
    logic              busy;
    logic [63:0]       act_shadow;
    logic [63:0]       lock_cfg;

    int total = 0;
    int bad = 0;
    logic [31:0] rd;

    always #10 clk = ~clk;

    fsr_regfile #(.ADDR_W(ADDR_W), .DW(DW), .CNT_W(CNT_W)) i_fsr_regfile (
        .clk(clk), .rst_n(rst_n),
        .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_be(bus_be),
        .bus_rvalid(bus_rvalid), .bus_rdata(bus_rdata), .bus_resp(bus_resp),
        .frame_start(frame_start), .frame_end(frame_end),
        .hit_valid(hit_valid), .hit_bin(hit_bin),
        .busy(busy), .act_shadow(act_shadow), .lock_cfg(lock_cfg)
    );

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic bus_op(input logic we, input logic [ADDR_W-1:0] a,
                          input logic [31:0] d, input logic [3:0] be,
                          output logic [31:0] r);
        @(negedge clk);
        bus_req = 1'b1; bus_we = we; bus_addr = a; bus_wdata = d; bus_be = be;
        @(negedge clk);
        bus_req = 1'b0; bus_we = 1'b0;
        r = bus_rdata;
        check("R10 resp", {63'd0, bus_rvalid} | {62'd0, bus_resp, 1'b0} << 1, 64'd1);
    endtask

    task automatic pulse_sof();
        @(negedge clk); frame_start = 1'b1;
        @(negedge clk); frame_start = 1'b0;
    endtask

    task automatic pulse_eof();
        @(negedge clk); frame_end = 1'b1;
        @(negedge clk); frame_end = 1'b0;
    endtask

    task automatic hits(input int n, input logic [2:0] b);
        @(negedge clk); hit_valid = 1'b1; hit_bin = b;
        repeat (n) @(negedge clk);
        hit_valid = 1'b0;
    endtask

    typedef struct packed {
        logic        we;
        logic [5:0]  addr;
        logic [31:0] wdata;
        logic [3:0]  be;
        logic [31:0] exp;
    } vec_t;

    // R2 R5 R11 R6 R1 idle-phase register traffic
    localparam vec_t VECS [10] = '{
        '{1'b1, 6'd2,  32'h11223344, 4'hF, 32'h0},
        '{1'b0, 6'd2,  32'h0,        4'hF, 32'h11223344},
        '{1'b1, 6'd4,  32'hAABBCCDD, 4'hF, 32'h0},
        '{1'b0, 6'd4,  32'h0,        4'h0, 32'hAABBCCDD},
        '{1'b1, 6'd5,  32'hFFFFFFFF, 4'h5, 32'h0},
        '{1'b0, 6'd5,  32'h0,        4'hF, 32'h00FF00FF},
        '{1'b1, 6'd3,  32'hCAFEF00D, 4'hC, 32'h0},
        '{1'b0, 6'd3,  32'h0,        4'h3, 32'hCAFE0000},
        '{1'b0, 6'd35, 32'h0,        4'hF, 32'h0},
        '{1'b0, 6'd7,  32'h0,        4'hF, 32'h0}
    };

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 busy", {63'd0, busy}, 64'd0);
        check("R1 act_shadow", act_shadow, 64'd0);
        check("R1 lock_cfg", lock_cfg, 64'd0);
        bus_op(1'b0, 6'd0, 32'h0, 4'hF, rd);
        check("R1 ctrl", {32'd0, rd}, 64'd0);
        @(negedge clk);
        check("R10 no spurious", {63'd0, bus_rvalid}, 64'd0);

        for (int i = 0; i < 10; i++) begin
            bus_op(VECS[i].we, VECS[i].addr, VECS[i].wdata, VECS[i].be, rd);
            if (!VECS[i].we) check("R2/R5/R11 table read", {32'd0, rd}, {32'd0, VECS[i].exp});
        end

        check("R2 act held before sof", act_shadow, 64'd0);
        check("R5 lock_cfg direct", lock_cfg, 64'h00FF00FF_AABBCCDD);

        // one-shot frame
        bus_op(1'b1, 6'd0, 32'h1, 4'h1, rd);
        pulse_sof();
        check("R3 busy rise", {63'd0, busy}, 64'd1);
        check("R2 act commit", act_shadow, 64'hCAFE0000_11223344);
        bus_op(1'b0, 6'd0, 32'h0, 4'hF, rd);
        check("R7 enable auto-clear", {32'd0, rd}, 64'd0);
        bus_op(1'b1, 6'd2, 32'h00000055, 4'hF, rd);
        bus_op(1'b0, 6'd2, 32'h0, 4'hF, rd);
        check("R2 readback while busy", {32'd0, rd}, 64'h55);
        check("R2 act unchanged", act_shadow, 64'hCAFE0000_11223344);
        bus_op(1'b1, 6'd4, 32'h00001234, 4'hF, rd);
        bus_op(1'b0, 6'd4, 32'h0, 4'hF, rd);
        check("R4 lock write blocked", {32'd0, rd}, 64'hAABBCCDD);
        bus_op(1'b1, 6'd0, 32'h2, 4'h1, rd);
        bus_op(1'b0, 6'd0, 32'h0, 4'hF, rd);
        check("R4 mode write blocked", {32'd0, rd}, 64'd0);
        hits(3, 3'd2);
        bus_op(1'b0, 6'd34, 32'h0, 4'h0, rd);
        check("R6 poison while busy", {32'd0, rd}, {32'd0, POISON});
        bus_op(1'b1, 6'd6, 32'h1, 4'hF, rd);
        pulse_eof();
        check("R3 busy fall", {63'd0, busy}, 64'd0);
        bus_op(1'b0, 6'd34, 32'h0, 4'h0, rd);
        check("R6/R9 count idle, clear during busy ignored (R4)", {32'd0, rd}, 64'd3);

        pulse_sof();
        check("R7 no restart without enable", {63'd0, busy}, 64'd0);
        check("R2 commit on idle sof", act_shadow, 64'hCAFE0000_00000055);
        hits(2, 3'd2);
        bus_op(1'b0, 6'd34, 32'h0, 4'hF, rd);
        check("R9 idle hits ignored", {32'd0, rd}, 64'd3);
        bus_op(1'b1, 6'd4, 32'h00001234, 4'hF, rd);
        check("R5 lock writable idle", lock_cfg, 64'h00FF00FF_00001234);

        // continuous mode
        bus_op(1'b1, 6'd0, 32'h3, 4'h1, rd);
        pulse_sof();
        check("R8 cont start", {63'd0, busy}, 64'd1);
        hits(1, 3'd2);
        pulse_eof();
        bus_op(1'b0, 6'd0, 32'h0, 4'hF, rd);
        check("R8 enable kept", {32'd0, rd}, 64'd3);
        pulse_sof();
        check("R8 back-to-back", {63'd0, busy}, 64'd1);
        bus_op(1'b1, 6'd0, 32'h2, 4'h1, rd);
        repeat (3) @(negedge clk);
        check("R8 busy held after disable", {63'd0, busy}, 64'd1);
        hits(1, 3'd2);
        pulse_eof();
        check("R8 frame ends", {63'd0, busy}, 64'd0);
        pulse_sof();
        check("R8 no further frame", {63'd0, busy}, 64'd0);
        bus_op(1'b0, 6'd34, 32'h0, 4'hF, rd);
        check("R9 accumulate", {32'd0, rd}, 64'd5);

        // saturation and clear
        bus_op(1'b1, 6'd0, 32'h3, 4'h1, rd);
        pulse_sof();
        hits(20, 3'd5);
        bus_op(1'b1, 6'd0, 32'h2, 4'h1, rd);
        pulse_eof();
        bus_op(1'b0, 6'd37, 32'h0, 4'hF, rd);
        check("R9 saturate", {32'd0, rd}, 64'd15);
        bus_op(1'b1, 6'd6, 32'h1, 4'hF, rd);
        bus_op(1'b0, 6'd34, 32'h0, 4'hF, rd);
        check("R9 clear bin2", {32'd0, rd}, 64'd0);
        bus_op(1'b0, 6'd37, 32'h0, 4'hF, rd);
        check("R9 clear bin5", {32'd0, rd}, 64'd0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule